// File: doc/BRIEF.md
# Bus Clock Divider Pair Search

This unit turns a source clock rate and a requested serial bus rate into the two 16-bit timing words that a two-wire bus master's clock generator loads. The bus period is built from two nested counts, a sample count of 1 to 8 and a step count. The unit looks for the pair whose product is the smallest value that still meets the required division ratio. It then packs the pair into a standard-mode or high-speed layout, depending on the requested rate.

A one-cycle start pulse latches the source rate (after any fixed pre-division) and the target rate. The unit runs one shared multi-cycle restoring divider in sequence: once for the required ratio, once per sample candidate, and once to check the result. When a candidate hits the ratio exactly, the search stops early. This shortens latency and leaves the result unchanged. The unit then gives a one-cycle done pulse, an error flag and the two words. All of these hold until the next result.

Top module: `i2c_pair_search`

## Requirements
- R1: A target rate above 3,400,000 Hz is treated as exactly 3,400,000 Hz.
- R2: The clamped target selects the mode. Above 400,000 Hz the mode is high-speed and the step count limit is 8. At or below 400,000 Hz the limit is 64 (400,000 itself is standard mode).
- R3: The required ratio is ceil(floor(src/2) / target). The divider's quotient and remainder always satisfy quotient*divisor + remainder = dividend, with remainder < divisor.
- R4: For each sample count s from 1 to 8, the candidate step is ceil(ratio/s). A candidate whose step exceeds the limit is skipped. The chosen pair has the smallest product among the kept candidates. On equal products the smaller s is kept.
- R5: If no candidate is kept, the pair is s = 8 with step equal to the mode limit.
- R6: err is 1 exactly when floor(src / (2*s*step)) is strictly greater than the clamped target. Equality gives err = 0.
- R7: In standard mode, timing_word holds s-1 in bits 10:8 and step-1 in bits 5:0, with all other bits 0, and hs_word is 0.
- R8: In high-speed mode, timing_word is 16'h1303 and hs_word holds s-1 in bits 14:12, step-1 in bits 10:8 and 2'b11 in bits 1:0, with all other bits 0.
- R9: done is high for exactly one cycle per accepted start. err and both words are valid in that cycle and hold afterwards.
- R10: A start pulse that arrives while a computation is in progress is ignored. It produces no extra done, and its inputs do not affect the result in progress.
- R11: After reset, done, err, timing_word and hs_word are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request; sampled only when idle |
| src_hz | input | RATE_W | Source clock rate after pre-division, in Hz |
| tgt_hz | input | RATE_W | Requested bus rate, in Hz |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Requested rate cannot be reached (too slow) |
| timing_word | output | 16 | Packed standard-mode timing word |
| hs_word | output | 16 | Packed high-speed timing word |

## Verification
The assertions assume that the target rate is at least 1 Hz and the source rate at least 2 Hz. Under these assumptions no division has a zero divisor and the required ratio is never zero. They also assume that start is a single-cycle pulse. The bench only drives rates well inside these bounds. It holds start high for one cycle per request and drives a second, differing request only while a computation is running. The assertions on the packed words apply only in the done cycle, because only then are the chosen pair and the mode bound to the outputs.

// File: rtl/pairsrch_pkg.sv
package pairsrch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPT_GO,
    ST_OPT_WAIT,
    ST_SRCH_GO,
    ST_SRCH_WAIT,
    ST_CHK_GO,
    ST_CHK_WAIT
  } srch_state_e;

  localparam int WORD_W = 16;

  // standard-mode layout: sample-1 at 10:8, step-1 at 5:0
  function automatic logic [WORD_W-1:0] pack_std(input logic [2:0] smp_m1,
                                                 input logic [5:0] stp_m1);
    return {5'b0, smp_m1, 2'b0, stp_m1};
  endfunction

  // high-speed layout: sample-1 at 14:12, step-1 at 10:8, low two bits set
  function automatic logic [WORD_W-1:0] pack_hs(input logic [2:0] smp_m1,
                                                input logic [2:0] stp_m1);
    return {1'b0, smp_m1, 1'b0, stp_m1, 8'h03};
  endfunction

  localparam logic [WORD_W-1:0] HS_TIMING_FIXED = 16'h1303;

endpackage

// File: rtl/pairsrch_div.sv
module pairsrch_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  q_r, d_r, n_r, r_r;
  logic [CW-1:0] cnt_r;
  logic          done_r;
  logic [W:0]    shifted, diff;
  logic          fits;

  always_comb begin
    shifted = {r_r, q_r[W-1]};
    diff    = shifted - {1'b0, d_r};
    fits    = shifted >= {1'b0, d_r};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r    <= '0;
      d_r    <= '0;
      n_r    <= '0;
      r_r    <= '0;
      cnt_r  <= '0;
      done_r <= 1'b0;
    end else if (go && cnt_r == '0) begin
      q_r    <= dividend;
      n_r    <= dividend;
      d_r    <= divisor;
      r_r    <= '0;
      cnt_r  <= CW'(W);
      done_r <= 1'b0;
    end else if (cnt_r != '0) begin
      r_r    <= fits ? diff[W-1:0] : shifted[W-1:0];
      q_r    <= {q_r[W-2:0], fits};
      cnt_r  <= cnt_r - 1'b1;
      done_r <= (cnt_r == CW'(1));
    end else begin
      done_r <= 1'b0;
    end
  end

  assign busy = (cnt_r != '0);
  assign done = done_r;
  assign quo  = q_r;
  assign rem  = r_r;

  assert_div_identity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((64'(q_r) * 64'(d_r) + 64'(r_r)) == 64'(n_r)));
  assert_div_rem_below_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (r_r < d_r));
endmodule

// File: rtl/pairsrch_pack.sv
module pairsrch_pack
  import pairsrch_pkg::*;
#(
  parameter int SMP_W = 4,
  parameter int STP_W = 7
) (
  input  logic              hs_mode,
  input  logic [SMP_W-1:0]  smp,
  input  logic [STP_W-1:0]  stp,
  output logic [WORD_W-1:0] timing_w,
  output logic [WORD_W-1:0] hs_w
);
  logic [SMP_W-1:0] smp_m1;
  logic [STP_W-1:0] stp_m1;

  always_comb begin
    smp_m1 = smp - 1'b1;
    stp_m1 = stp - 1'b1;
    if (hs_mode) begin
      timing_w = HS_TIMING_FIXED;
      hs_w     = pack_hs(smp_m1[2:0], stp_m1[2:0]);
    end else begin
      timing_w = pack_std(smp_m1[2:0], stp_m1[5:0]);
      hs_w     = '0;
    end
  end
endmodule

// File: rtl/i2c_pair_search.sv
module i2c_pair_search
  import pairsrch_pkg::*;
#(
  parameter int RATE_W      = 32,
  parameter int CLAMP_HZ    = 3400000,
  parameter int FS_MAX_HZ   = 400000,
  parameter int SAMPLE_MAX  = 8,
  parameter int STEP_MAX_FS = 64,
  parameter int STEP_MAX_HS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] src_hz,
  input  logic [RATE_W-1:0] tgt_hz,
  output logic              done,
  output logic              err,
  output logic [15:0]       timing_word,
  output logic [15:0]       hs_word
);
  localparam int SMP_W  = $clog2(SAMPLE_MAX + 1);
  localparam int STP_W  = $clog2(STEP_MAX_FS + 1);
  localparam int PROD_W = $clog2(SAMPLE_MAX * STEP_MAX_FS + 1) + 1;

  srch_state_e       state;
  logic [RATE_W-1:0] src_r, tgt_r, opt_r;
  logic              hs_r;
  logic [STP_W-1:0]  max_step;
  logic [SMP_W-1:0]  s_r, best_s;
  logic [STP_W-1:0]  best_st;
  logic [PROD_W-1:0] best_mul;
  logic              done_r, err_r;
  logic [15:0]       timing_r, hsw_r;

  // named events
  logic              accept;
  logic [RATE_W-1:0] tgt_c;
  logic              div_go, div_busy, div_done;
  logic [RATE_W-1:0] div_a, div_b, quo, rem;
  logic [RATE_W-1:0] ceil_q;
  logic              step_fits, cand_better, exact_hit, last_cand;
  logic [PROD_W-1:0] prod;
  logic [15:0]       pk_timing, pk_hs;

  assign accept = start && (state == ST_IDLE);
  assign tgt_c  = (tgt_hz > RATE_W'(CLAMP_HZ)) ? RATE_W'(CLAMP_HZ) : tgt_hz;

  always_comb begin
    div_go = 1'b0;
    div_a  = '0;
    div_b  = '0;
    case (state)
      ST_OPT_GO:  begin div_go = 1'b1; div_a = src_r >> 1; div_b = tgt_r; end
      ST_SRCH_GO: begin div_go = 1'b1; div_a = opt_r; div_b = RATE_W'(s_r); end
      ST_CHK_GO:  begin div_go = 1'b1; div_a = src_r; div_b = RATE_W'(best_mul) << 1; end
      default: ;
    endcase
  end

  pairsrch_div #(.W(RATE_W)) div_i (
    .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(div_a), .divisor(div_b),
    .busy(div_busy), .done(div_done), .quo(quo), .rem(rem)
  );

  always_comb begin
    ceil_q      = quo + RATE_W'(rem != '0);
    step_fits   = ceil_q <= RATE_W'(max_step);
    prod        = PROD_W'(ceil_q[STP_W-1:0]) * PROD_W'(s_r);
    cand_better = step_fits && (prod < best_mul);
    exact_hit   = cand_better && (RATE_W'(prod) == opt_r);
    last_cand   = (s_r == SMP_W'(SAMPLE_MAX));
  end

  pairsrch_pack #(.SMP_W(SMP_W), .STP_W(STP_W)) pack_i (
    .hs_mode(hs_r), .smp(best_s), .stp(best_st),
    .timing_w(pk_timing), .hs_w(pk_hs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      src_r    <= '0;
      tgt_r    <= '0;
      opt_r    <= '0;
      hs_r     <= 1'b0;
      max_step <= '0;
      s_r      <= '0;
      best_s   <= '0;
      best_st  <= '0;
      best_mul <= '0;
      done_r   <= 1'b0;
      err_r    <= 1'b0;
      timing_r <= '0;
      hsw_r    <= '0;
    end else begin
      done_r <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          src_r    <= src_hz;
          tgt_r    <= tgt_c;
          hs_r     <= tgt_c > RATE_W'(FS_MAX_HZ);
          max_step <= (tgt_c > RATE_W'(FS_MAX_HZ)) ? STP_W'(STEP_MAX_HS)
                                                   : STP_W'(STEP_MAX_FS);
          state    <= ST_OPT_GO;
        end
        ST_OPT_GO:  state <= ST_OPT_WAIT;
        ST_OPT_WAIT: if (div_done) begin
          opt_r    <= ceil_q;
          s_r      <= SMP_W'(1);
          best_s   <= SMP_W'(SAMPLE_MAX);
          best_st  <= max_step;
          best_mul <= PROD_W'(SAMPLE_MAX) * PROD_W'(max_step);
          state    <= ST_SRCH_GO;
        end
        ST_SRCH_GO: state <= ST_SRCH_WAIT;
        ST_SRCH_WAIT: if (div_done) begin
          if (cand_better) begin
            best_mul <= prod;
            best_s   <= s_r;
            best_st  <= ceil_q[STP_W-1:0];
          end
          if (exact_hit || last_cand) state <= ST_CHK_GO;
          else begin
            s_r   <= s_r + 1'b1;
            state <= ST_SRCH_GO;
          end
        end
        ST_CHK_GO: state <= ST_CHK_WAIT;
        ST_CHK_WAIT: if (div_done) begin
          err_r    <= quo > tgt_r;
          timing_r <= pk_timing;
          hsw_r    <= pk_hs;
          done_r   <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done        = done_r;
  assign err         = err_r;
  assign timing_word = timing_r;
  assign hs_word     = hsw_r;

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state != ST_IDLE) |=> ($stable(tgt_r) && $stable(src_r)));
  assert_hs_layout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && hs_r) |-> (timing_word == 16'h1303 && hs_word[1:0] == 2'b11));
  assert_std_layout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !hs_r) |-> (hs_word == 16'h0000));
  assert_step_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (best_st != '0 && best_st <= max_step));
  assert_sample_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (best_s != '0 && best_s <= SMP_W'(SAMPLE_MAX)));
  assert_div_idle_go_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |-> !div_busy);
endmodule

// File: tb/i2c_pair_search_tb_top.sv
module i2c_pair_search_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] src_hz = '0;
  logic [31:0] tgt_hz = '0;
  logic        done, err;
  logic [15:0] timing_word, hs_word;

  always #2.5 clk = ~clk;

  i2c_pair_search dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .src_hz(src_hz), .tgt_hz(tgt_hz),
    .done(done), .err(err), .timing_word(timing_word), .hs_word(hs_word)
  );

  typedef struct {
    logic        e;
    logic [15:0] tw;
    logic [15:0] hw;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   cycles = 0;
  logic prev_done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(input longint src, input longint tgt, input string tag);
    exp_t   r;
    longint t, mx, opt, best, bs, bst, st;
    bit     hs;
    t   = (tgt > 3400000) ? 3400000 : tgt;
    hs  = t > 400000;
    mx  = hs ? 8 : 64;
    opt = ((src / 2) + t - 1) / t;
    best = 8 * mx; bs = 8; bst = mx;
    for (int s = 1; s <= 8; s++) begin
      st = (opt + s - 1) / s;
      if (st <= mx && st * s < best) begin
        best = st * s; bs = s; bst = st;
        if (best == opt) break;
      end
    end
    r.e = (src / (2 * bs * bst)) > t;
    if (hs) begin
      r.tw = 16'h1303;
      r.hw = 16'h0003 | 16'((bs - 1) << 12) | 16'((bst - 1) << 8);
    end else begin
      r.tw = 16'((bs - 1) << 8) | 16'(bst - 1);
      r.hw = 16'h0000;
    end
    r.tag = tag;
    return r;
  endfunction

  task automatic run(input longint src, input longint tgt, input string tag);
    exp_q.push_back(model(src, tgt, tag));
    @(negedge clk);
    src_hz = 32'(src); tgt_hz = 32'(tgt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        check(!prev_done, "R9", "done longer than one cycle", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected done", 1, 0);
        end else begin
          exp_t x;
          x = exp_q.pop_front();
          check(err == x.e, x.tag, "err", err, x.e);
          check(timing_word == x.tw, x.tag, "timing_word", timing_word, x.tw);
          check(hs_word == x.hw, x.tag, "hs_word", hs_word, x.hw);
        end
      end
      prev_done <= done;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 200000) begin
      check(1'b0, "WD", "watchdog expired", cycles, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R11", "reset done", done, 0);
    check(err == 1'b0, "R11", "reset err", err, 0);
    check(timing_word == 16'h0, "R11", "reset timing_word", timing_word, 0);
    check(hs_word == 16'h0, "R11", "reset hs_word", hs_word, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(13000000, 100000,  "R3 R4 R6 R7 exact, err boundary");
    run(13400000, 100000,  "R4 tie keeps smaller sample");
    run(13000000, 3400000, "R8 high-speed");
    run(13000000, 5000000, "R1 clamp");
    run(200000000, 100000, "R5 R6 no candidate std");
    run(200000000, 1000000,"R5 R6 R8 no candidate hs");
    run(26000000, 400000,  "R2 400k is standard");
    run(26000000, 400001,  "R2 above 400k is high-speed");
    run(50000000, 1000000, "R2 R4 hs skips");
    run(27000000, 250000,  "R3 R7 sample one");
    run(100000000, 3400000,"R4 R8 hs exact");

    // R10: second request while busy
    exp_q.push_back(model(13000000, 100000, "R10 busy start ignored"));
    @(negedge clk);
    src_hz = 32'd13000000; tgt_hz = 32'd100000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    src_hz = 32'd200000000; tgt_hz = 32'd1000000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (exp_q.size() == 0);
    repeat (400) @(negedge clk);
    check(exp_q.size() == 0, "R10", "pending results", exp_q.size(), 0);
    check(timing_word == 16'h040C, "R9 R10", "held timing_word", timing_word, 16'h040C);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule